// File: doc/BRIEF.md
# Tick Timer with Write-Blocked Compare

This block is a free-standing counter, eight bits wide by default, that advances once per timer tick. A tick comes from a prescaler that divides the system clock by a selectable ratio. An equality comparator checks the count against a compare register on every tick. When they are equal, the comparator sets a sticky compare flag and sends a one-cycle match pulse to a downstream waveform unit. The counter either runs freely and wraps from all-ones to zero, which sets a sticky overflow flag, or returns to zero on each compare match.

A host can load the counter directly over its write port. That load masks the compare on the first tick that follows, even when the prescaler is stopped. Software can therefore set the compare register equal to the count while the timer is halted, and starting the timer does not produce a spurious match. The drawback is that a load whose value equals the compare register loses that match. Each flag is cleared by writing a one to its bit of the clear input.

Top module: `tick_timer`

## Requirements
- R1: After reset the count is 0, both flags are 0 and the match pulse is 0.
- R2: The prescaler select `presc_sel` picks the tick rate. 1 gives a tick every clock, 2 every 8th clock, 3 every 64th, 4 every 256th and 5 every 1024th. The divider runs freely from reset, so a tick falls on clock k (counted from 0 after reset) when k mod N equals N-1. Values 0, 6 and 7 stop the counter, which then holds its value.
- R3: In free-running mode (`ctc_mode`=0), the count goes up by one on each tick and wraps from 8'hFF to 8'h00. A tick taken at 8'hFF sets `ovf_flag` (bit 0 of the flag set).
- R4: A tick taken while the count equals the compare register, with no blocking in force, sets `cmp_flag` (bit 1). The same clock edge that sets the flag also drives `match_pulse` high for one cycle.
- R5: In clear-on-compare mode (`ctc_mode`=1), an unblocked match loads 0 into the counter in place of the increment.
- R6: A counter write loads `cnt_wr_data` at the next edge. The write takes priority over a tick in the same cycle, so that tick neither advances the count nor sets a flag.
- R7: A counter write blocks the compare in its own cycle and on the first tick after it. The block holds across any number of stopped cycles, so a match on that tick is lost.
- R8: A one on bit 0 or bit 1 of `flag_clr` clears the overflow flag or the compare flag. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R9: A compare-register write takes effect for the first tick after it, whether or not the prescaler is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_sel | input | 3 | Tick-rate select (0 = stopped) |
| ctc_mode | input | 1 | 0 = free-running, 1 = clear on compare |
| cnt_wr_en | input | 1 | Counter load strobe |
| cnt_wr_data | input | 8 | Counter load value |
| cmp_wr_en | input | 1 | Compare register write strobe |
| cmp_wr_data | input | 8 | Compare register value |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 compare |
| count | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |
| match_pulse | output | 1 | One-cycle compare-match event |

## Verification
Two pairs of events can land in the same clock. The first pair is a counter write and a tick. The bench provokes it by loading the counter while the select gives a tick on every clock, and it expects the loaded value with no increment and a masked compare on the following tick. The second pair is a flag set and a flag clear. The bench holds the compare-flag clear high while clear-on-compare matches keep arriving, and it expects the flag to read one in the cycles where a match lands. A behavioural model, updated on every edge, judges both cases.

// File: rtl/tick_pkg.sv
package tick_pkg;
   localparam int FLAG_OVF = 0;
   localparam int FLAG_CMP = 1;
   localparam int N_FLAGS  = 2;
   localparam int N_DIV    = 5;

   function automatic int div_shift(input int idx);
      case (idx)
         0:       return 0;
         1:       return 3;
         2:       return 6;
         3:       return 8;
         default: return 10;
      endcase
   endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
   parameter int SEL_W = 3,
   parameter int PRE_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int NSRC = tick_pkg::N_DIV;

   if (PRE_W < tick_pkg::div_shift(NSRC - 1)) begin : g_bad_pre
      $error("tick_prescaler: PRE_W too small for largest ratio");
   end
   if ((1 << SEL_W) <= NSRC) begin : g_bad_sel
      $error("tick_prescaler: SEL_W cannot address all ratios");
   end

   logic [PRE_W-1:0] pre_q;
   logic [NSRC:0]    src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   assign src[0] = 1'b0;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      localparam int SH = tick_pkg::div_shift(i);
      if (SH == 0) begin : g_full
         assign src[i+1] = 1'b1;
      end else begin : g_div
         assign src[i+1] = &pre_q[SH-1:0];
      end
   end

   always_comb begin
      tick = 1'b0;
      for (int k = 0; k <= NSRC; k++) begin
         if (int'(sel) == k) tick = src[k];
      end
   end
endmodule

// File: rtl/tick_core.sv
module tick_core #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr_mode,
   input  logic             wr_cnt,
   input  logic [CNT_W-1:0] wr_cnt_data,
   input  logic             wr_cmp,
   input  logic [CNT_W-1:0] wr_cmp_data,
   output logic [CNT_W-1:0] cnt_q,
   output logic             pulse_q,
   output logic             ovf_set,
   output logic             cmp_set
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_BOT = '0;

   if (CNT_W < 2) begin : g_bad_w
      $error("tick_core: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] cnt_d;
   logic             blk_q;
   logic             eq;
   logic             live_tick;
   logic             hit;

   assign eq        = (cnt_q == cmp_q);
   assign live_tick = tick & ~wr_cnt;
   assign hit       = live_tick & ~blk_q & eq;
   assign ovf_set   = live_tick & (cnt_q == CNT_MAX);
   assign cmp_set   = hit;

   always_comb begin
      cnt_d = cnt_q;
      if (wr_cnt)          cnt_d = wr_cnt_data;
      else if (tick) begin
         if (hit && clr_mode) cnt_d = CNT_BOT;
         else                 cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= CNT_BOT;
         cmp_q   <= CNT_BOT;
         blk_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         pulse_q <= hit;
         if (wr_cmp) cmp_q <= wr_cmp_data;
         if (wr_cnt)    blk_q <= 1'b1;
         else if (tick) blk_q <= 1'b0;
      end
   end
endmodule

// File: rtl/tick_flags.sv
module tick_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag[i] <= 1'b0;
         else if (set[i]) flag[i] <= 1'b1;
         else if (clr[i]) flag[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
   parameter int CNT_W = 8,
   parameter int SEL_W = 3,
   parameter int PRE_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] presc_sel,
   input  logic             ctc_mode,
   input  logic             cnt_wr_en,
   input  logic [CNT_W-1:0] cnt_wr_data,
   input  logic             cmp_wr_en,
   input  logic [CNT_W-1:0] cmp_wr_data,
   input  logic [1:0]       flag_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf_flag,
   output logic             cmp_flag,
   output logic             match_pulse
);
   localparam int NF = tick_pkg::N_FLAGS;

   logic          tick;
   logic          ovf_set;
   logic          cmp_set;
   logic [NF-1:0] fl_set;
   logic [NF-1:0] fl_q;

   tick_prescaler #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (presc_sel),
      .tick (tick)
   );

   tick_core #(.CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .clr_mode   (ctc_mode),
      .wr_cnt     (cnt_wr_en),
      .wr_cnt_data(cnt_wr_data),
      .wr_cmp     (cmp_wr_en),
      .wr_cmp_data(cmp_wr_data),
      .cnt_q      (count),
      .pulse_q    (match_pulse),
      .ovf_set    (ovf_set),
      .cmp_set    (cmp_set)
   );

   always_comb begin
      fl_set = '0;
      fl_set[tick_pkg::FLAG_OVF] = ovf_set;
      fl_set[tick_pkg::FLAG_CMP] = cmp_set;
   end

   tick_flags #(.N(NF)) u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (fl_set),
      .clr  (flag_clr),
      .flag (fl_q)
   );

   assign ovf_flag = fl_q[tick_pkg::FLAG_OVF];
   assign cmp_flag = fl_q[tick_pkg::FLAG_CMP];
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int CNT_W = 8,
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SEL_W-1:0] presc_sel,
   input logic             cnt_wr_en,
   input logic [CNT_W-1:0] cnt_wr_data,
   input logic [1:0]       flag_clr,
   input logic [CNT_W-1:0] count,
   input logic             ovf_flag,
   input logic             cmp_flag,
   input logic             match_pulse
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   p_write_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_en |=> (count == $past(cnt_wr_data)));

   p_write_masks_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_en |=> !match_pulse);

   p_pulse_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> cmp_flag);

   p_stopped_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (presc_sel == '0 && !cnt_wr_en) |=> $stable(count));

   p_ovf_on_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> ($past(count) == CMAX));

   p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[0] && count != CMAX) |=> !ovf_flag);

   p_cmp_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr[1] |=> (!cmp_flag || match_pulse));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] presc_sel = '0;
   logic       ctc_mode = 1'b0;
   logic       cnt_wr_en = 1'b0;
   logic [7:0] cnt_wr_data = '0;
   logic       cmp_wr_en = 1'b0;
   logic [7:0] cmp_wr_data = '0;
   logic [1:0] flag_clr = '0;
   logic [7:0] count;
   logic       ovf_flag, cmp_flag, match_pulse;

   int checks = 0, fails = 0;
   bit done = 0, cmp_on = 0;

   // reference model state
   int m_cnt, m_ocr, cyc;
   bit m_blk, m_ovf, m_cmp, m_pulse;

   always #10 clk = ~clk;

   tick_timer u_dut (
      .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .ctc_mode(ctc_mode),
      .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
      .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
      .flag_clr(flag_clr), .count(count), .ovf_flag(ovf_flag),
      .cmp_flag(cmp_flag), .match_pulse(match_pulse)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_ocr = 0; cyc = 0;
         m_blk = 0; m_ovf = 0; m_cmp = 0; m_pulse = 0;
      end else begin
         bit t, hit, wrap;
         case (presc_sel)
            3'd1:    t = 1;
            3'd2:    t = (cyc % 8) == 7;
            3'd3:    t = (cyc % 64) == 63;
            3'd4:    t = (cyc % 256) == 255;
            3'd5:    t = (cyc % 1024) == 1023;
            default: t = 0;
         endcase
         hit  = t && !cnt_wr_en && !m_blk && (m_cnt == m_ocr);
         wrap = t && !cnt_wr_en && (m_cnt == 255);
         if (wrap) m_ovf = 1; else if (flag_clr[0]) m_ovf = 0;
         if (hit)  m_cmp = 1; else if (flag_clr[1]) m_cmp = 0;
         m_pulse = hit;
         if (cnt_wr_en) m_cnt = int'(cnt_wr_data);
         else if (t)    m_cnt = (hit && ctc_mode) ? 0 : (m_cnt + 1) % 256;
         if (cnt_wr_en) m_blk = 1; else if (t) m_blk = 0;
         if (cmp_wr_en) m_ocr = int'(cmp_wr_data);
         cyc++;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         chk("R2 R6 count", int'(count), m_cnt);
         chk("R3 R8 ovf_flag", int'(ovf_flag), int'(m_ovf));
         chk("R4 R8 cmp_flag", int'(cmp_flag), int'(m_cmp));
         chk("R4 match_pulse", int'(match_pulse), int'(m_pulse));
      end
   end

   task automatic wr_cnt(input logic [7:0] v);
      @(negedge clk); cnt_wr_en = 1; cnt_wr_data = v;
      @(negedge clk); cnt_wr_en = 0;
   endtask

   task automatic wr_ocr(input logic [7:0] v);
      @(negedge clk); cmp_wr_en = 1; cmp_wr_data = v;
      @(negedge clk); cmp_wr_en = 0;
   endtask

   task automatic clr_flags();
      @(negedge clk); flag_clr = 2'b11;
      @(negedge clk); flag_clr = 2'b00;
   endtask

   task automatic finish_run();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      bit seen;
      logic [7:0] held;
      repeat (3) @(negedge clk);
      chk("R1 count", int'(count), 0);
      chk("R1 ovf_flag", int'(ovf_flag), 0);
      chk("R1 cmp_flag", int'(cmp_flag), 0);
      chk("R1 match_pulse", int'(match_pulse), 0);
      rst_n = 1; cmp_on = 1;

      // R3: free-running wrap at full rate
      presc_sel = 3'd1;
      repeat (300) @(negedge clk);
      chk("R3 overflow after wrap", int'(ovf_flag), 1);

      // R8: write-one clear while stopped
      presc_sel = 3'd0;
      clr_flags();
      chk("R8 ovf cleared", int'(ovf_flag), 0);
      chk("R8 cmp cleared", int'(cmp_flag), 0);

      // R7: equal count and compare loaded while stopped
      fork wr_cnt(8'h40); wr_ocr(8'h40); join
      repeat (20) @(negedge clk);
      chk("R2 stopped holds", int'(count), 8'h40);
      presc_sel = 3'd1;
      repeat (3) @(negedge clk);
      chk("R7 first tick blocked", int'(cmp_flag), 0);
      chk("R2 full rate advance", int'(count), 8'h43);
      wr_cnt(8'h3E);
      repeat (3) @(negedge clk);
      chk("R4 match pulse", int'(match_pulse), 1);
      chk("R4 compare flag", int'(cmp_flag), 1);

      // R9: compare written while stopped, first tick matches
      presc_sel = 3'd0;
      @(negedge clk);
      held = count;
      @(negedge clk); cmp_wr_en = 1; cmp_wr_data = held;
      @(negedge clk); cmp_wr_en = 0; presc_sel = 3'd1;
      @(negedge clk);
      chk("R9 new compare used", int'(match_pulse), 1);

      // R5: clear-on-compare
      presc_sel = 3'd0; ctc_mode = 1;
      wr_ocr(8'h10); wr_cnt(8'h00); clr_flags();
      presc_sel = 3'd1;
      repeat (60) @(negedge clk);
      chk("R5 no overflow", int'(ovf_flag), 0);
      chk("R5 compare seen", int'(cmp_flag), 1);

      // R6: write collides with a tick
      wr_cnt(8'h80);
      chk("R6 write beats tick", int'(count), 8'h80);

      // R8: clear held while matches keep setting
      wr_cnt(8'h00);
      seen = 0;
      flag_clr = 2'b10;
      repeat (40) begin
         @(negedge clk);
         if (cmp_flag) seen = 1;
      end
      flag_clr = 2'b00;
      chk("R8 set wins over clear", int'(seen), 1);

      // R2: divided rates
      ctc_mode = 0;
      presc_sel = 3'd2; repeat (100)  @(negedge clk);
      presc_sel = 3'd3; repeat (300)  @(negedge clk);
      presc_sel = 3'd4; repeat (700)  @(negedge clk);
      presc_sel = 3'd5; repeat (2200) @(negedge clk);
      presc_sel = 3'd6;
      @(negedge clk);
      held = count;
      repeat (50) @(negedge clk);
      chk("R2 select 6 stopped", int'(count), int'(held));
      finish_run();
   end
endmodule